// File: doc/BRIEF.md
# Trigger Request Queue With Clear

This block keeps count of readout requests that have arrived but not yet been serviced. The front end it serves is double-buffered, so at most two events can be held at once. Requests come from two places: a rising edge on the trigger start line, or a rising edge on a host test-start line. The queue hands requests to a readout sequencer one at a time. It shows the in-process state, and it raises front-end busy so the trigger source holds off while both buffer halves are occupied.

A clear-most-recent command cancels the newest event. What it removes depends on the queue state:

- If anything is waiting, the clear removes one waiting request.
- If nothing is waiting but a readout is running, the clear aborts that running readout.
- If nothing is waiting and nothing is running, the clear has no effect.

The states are:

- `ST_IDLE`: nothing in process.
- `ST_LAUNCH`: a one-cycle grant. `seq_start` is high in this state.
- `ST_RUN`: the sequencer is reading out.

The transitions are:

- `ST_IDLE -> ST_LAUNCH` (grant): a request remains waiting after any clear in the same cycle.
- `ST_LAUNCH -> ST_RUN` (go): taken on the next cycle.
- `ST_LAUNCH -> ST_IDLE` (abort): a clear arrives with nothing waiting.
- `ST_RUN -> ST_IDLE` (complete): `seq_done` is high.
- `ST_RUN -> ST_IDLE` (abort): a clear arrives with nothing waiting and `seq_done` low.

Initialise forces `ST_IDLE` from any state. When `seq_done` and an aborting clear arrive on the same edge, completion wins.

Top module: `trig_req_queue`

## Requirements
- R1: After reset, and one cycle after `init` is sampled high, the block shows:
  - `pending`, `in_process`, `fe_busy`, `overflow` and `seq_start` all 0;
  - no `seq_abort` pulse;
  - no grant until a new start edge arrives.
- R2: When `builder_en` is 1, a 0-to-1 change of `trig_start` adds one waiting request on the clock edge where the 1 is first sampled. A level held high adds nothing more.
- R3: A 0-to-1 change of `host_start` adds one waiting request whatever the value of `builder_en`. It leaves a readout in progress running.
- R4: In `ST_IDLE` with a request waiting, the next edge grants it:
  - `seq_start` is high for exactly one cycle;
  - the waiting count drops by one;
  - `in_process` stays 1 until completion or abort.
- R5: `fe_busy` is 1 when two requests are waiting, or when one is in process and at least one is waiting. Otherwise it is 0, unless R11 applies.
- R6: `pending` is 1 exactly when one or two requests are waiting.
- R7: A clear behaves as follows when nothing is in process:
  - with nothing waiting, it changes nothing;
  - with one waiting, it removes that request and no grant follows;
  - with two waiting, it removes one and the other is granted.
- R8: A clear with nothing waiting while a request is in process aborts it:
  - `seq_abort` pulses for one cycle;
  - `in_process` falls;
  - no `blk_done` pulse follows.
- R9: A clear with a request waiting while one is in process removes only the waiting request. The readout keeps running.
- R10: When `builder_en` is 0:
  - trigger start edges are neither granted nor remembered;
  - a completed readout produces no `blk_done` pulse.
- R11: `force_busy` high drives `fe_busy` high regardless of the queue state.
- R12: The in-process request leaves the queue only when `seq_done` is sampled in `ST_RUN`. That edge returns to `ST_IDLE` and gives a one-cycle `blk_done` pulse. `blk_done` and `seq_abort` are never high together.
- R13: A start edge that arrives while two requests are already waiting is dropped. It sets `overflow`, which stays 1 until reset or `init`. The waiting count never exceeds two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous initialise; empties the queue and clears `overflow` |
| trig_start | input | 1 | Trigger start level; the rising edge requests a readout |
| host_start | input | 1 | Host test-start level; the rising edge requests a readout |
| clr_recent | input | 1 | Clear-most-recent level; acts on its rising edge |
| builder_en | input | 1 | 1 accepts trigger starts and reports completions |
| force_busy | input | 1 | Forces `fe_busy` high |
| seq_done | input | 1 | The sequencer has fully sent the current block |
| seq_start | output | 1 | One-cycle grant to the sequencer |
| seq_abort | output | 1 | One-cycle abort of the running readout |
| blk_done | output | 1 | One-cycle completion pulse |
| in_process | output | 1 | A request is granted and not yet finished |
| fe_busy | output | 1 | Back-pressure to the trigger source |
| pending | output | 1 | One or two requests are waiting |
| overflow | output | 1 | Sticky flag: a start edge was dropped |

## Verification
The hardest situation to reach is two requests waiting with nothing in process. The idle state grants on the very next edge, so that situation lasts exactly one cycle. The stimulus gets there by raising both start lines so that their edges land on the same clock. It then raises the clear line one cycle later, so that the clear meets the two-waiting, idle state and competes with the grant. The one-waiting, idle clear is reached the same way with a single start. An event scoreboard also confirms that no grant escapes from either case.

// File: rtl/trq_pkg.sv
package trq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_RUN    = 2'd2
    } trq_state_e;

    localparam int unsigned EDGE_TRIG = 0;
    localparam int unsigned EDGE_HOST = 1;
    localparam int unsigned EDGE_CLR  = 2;
    localparam int unsigned EDGE_N    = 3;
endpackage

// File: rtl/trq_edge.sv
module trq_edge #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar gi = 0; gi < N; gi++) begin : g_edge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[gi] <= 1'b0;
            else        prev_q[gi] <= lvl[gi];
        end
        assign rise[gi] = lvl[gi] & ~prev_q[gi];
    end
endmodule

// File: rtl/trq_count.sv
module trq_count #(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             add_trig,
    input  logic             add_host,
    input  logic             take_clr,
    input  logic             take_grant,
    output logic [CNT_W-1:0] wait_cnt,
    output logic             ovf
);
    localparam int unsigned SW = CNT_W + 2;

    logic [CNT_W-1:0] wait_q;
    logic             ovf_q;
    logic [SW-1:0]    base;
    logic [SW-1:0]    nxt;
    logic             spill;

    always_comb begin
        base  = SW'(wait_q) - SW'(take_clr) - SW'(take_grant);
        nxt   = base + SW'(add_trig) + SW'(add_host);
        spill = (nxt > SW'(DEPTH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
            ovf_q  <= 1'b0;
        end else if (init) begin
            wait_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            wait_q <= spill ? CNT_W'(DEPTH) : nxt[CNT_W-1:0];
            if (spill) ovf_q <= 1'b1;
        end
    end

    assign wait_cnt = wait_q;
    assign ovf      = ovf_q;

    assert_wait_cap_R13: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q <= CNT_W'(DEPTH));

    assert_ovf_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !init) |=> ovf_q);

    // R7: a clear and a grant in one cycle need two waiting requests
    assert_clear_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_clr && take_grant) |-> (wait_q >= CNT_W'(2)));
endmodule

// File: rtl/trq_fsm.sv
module trq_fsm
    import trq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic wait_avail,
    input  logic clr_run,
    input  logic seq_done,
    input  logic builder_en,
    output logic grant,
    output logic seq_start,
    output logic in_process,
    output logic abort_pulse,
    output logic done_pulse
);
    trq_state_e state_q;
    trq_state_e state_d;
    logic       abort_q;
    logic       done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (wait_avail) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = clr_run ? ST_IDLE : ST_RUN;
            ST_RUN: begin
                if (seq_done)     state_d = ST_IDLE;
                else if (clr_run) state_d = ST_IDLE;
            end
            default:   state_d = ST_IDLE;
        endcase
        if (init) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abort_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            abort_q <= !init && clr_run && (state_q != ST_IDLE)
                       && !((state_q == ST_RUN) && seq_done);
            done_q  <= !init && (state_q == ST_RUN) && seq_done && builder_en;
        end
    end

    assign grant       = (state_q == ST_IDLE) && wait_avail && !init;
    assign seq_start   = (state_q == ST_LAUNCH);
    assign in_process  = (state_q != ST_IDLE);
    assign abort_pulse = abort_q;
    assign done_pulse  = done_q;

    assert_start_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start);

    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_q |-> !in_process);

    assert_done_abort_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort_q && done_q));
endmodule

// File: rtl/trig_req_queue.sv
module trig_req_queue
    import trq_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic trig_start,
    input  logic host_start,
    input  logic clr_recent,
    input  logic builder_en,
    input  logic force_busy,
    input  logic seq_done,
    output logic seq_start,
    output logic seq_abort,
    output logic blk_done,
    output logic in_process,
    output logic fe_busy,
    output logic pending,
    output logic overflow
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [EDGE_N-1:0] lvl;
    logic [EDGE_N-1:0] rise;
    logic [CNT_W-1:0]  wait_cnt;
    logic              clr_hits_wait;
    logic              clr_run;
    logic              wait_avail;
    logic              grant;
    logic              add_trig;

    assign lvl[EDGE_TRIG] = trig_start;
    assign lvl[EDGE_HOST] = host_start;
    assign lvl[EDGE_CLR]  = clr_recent;

    trq_edge #(.N(EDGE_N)) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .rise  (rise)
    );

    assign add_trig      = rise[EDGE_TRIG] & builder_en;
    assign clr_hits_wait = rise[EDGE_CLR] & (wait_cnt != '0);
    assign clr_run       = rise[EDGE_CLR] & (wait_cnt == '0) & in_process;
    assign wait_avail    = (wait_cnt > CNT_W'(clr_hits_wait));

    trq_count #(.DEPTH(DEPTH), .CNT_W(CNT_W)) count_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (init),
        .add_trig   (add_trig),
        .add_host   (rise[EDGE_HOST]),
        .take_clr   (clr_hits_wait),
        .take_grant (grant),
        .wait_cnt   (wait_cnt),
        .ovf        (overflow)
    );

    trq_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .init        (init),
        .wait_avail  (wait_avail),
        .clr_run     (clr_run),
        .seq_done    (seq_done),
        .builder_en  (builder_en),
        .grant       (grant),
        .seq_start   (seq_start),
        .in_process  (in_process),
        .abort_pulse (seq_abort),
        .done_pulse  (blk_done)
    );

    assign pending = (wait_cnt != '0);
    assign fe_busy = force_busy
                   | (wait_cnt == CNT_W'(DEPTH))
                   | (in_process & (wait_cnt != '0));

    assert_clear_keeps_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rise[EDGE_CLR] && (wait_cnt != '0) && in_process && !seq_done && !init)
        |=> in_process);

    assert_force_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        force_busy |-> fe_busy);

    assert_no_trig_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!builder_en && rise[EDGE_TRIG] && !rise[EDGE_HOST] && !grant
         && !rise[EDGE_CLR] && !init) |=> $stable(wait_cnt));
endmodule

// File: tb/trig_req_queue_tb_top.sv
module trig_req_queue_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init = 1'b0, trig_start = 1'b0, host_start = 1'b0, clr_recent = 1'b0;
    logic builder_en = 1'b1, force_busy = 1'b0, seq_done = 1'b0;
    logic seq_start, seq_abort, blk_done, in_process, fe_busy, pending, overflow;

    int checks = 0;
    int fails  = 0;
    int expq[$];
    bit finished = 1'b0;

    localparam int EV_START = 1;
    localparam int EV_ABORT = 2;
    localparam int EV_DONE  = 3;

    always #5 clk = ~clk;

    trig_req_queue dut_i (
        .clk(clk), .rst_n(rst_n), .init(init), .trig_start(trig_start),
        .host_start(host_start), .clr_recent(clr_recent), .builder_en(builder_en),
        .force_busy(force_busy), .seq_done(seq_done), .seq_start(seq_start),
        .seq_abort(seq_abort), .blk_done(blk_done), .in_process(in_process),
        .fe_busy(fe_busy), .pending(pending), .overflow(overflow)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input int ev);
        expq.push_back(ev);
    endtask

    // monitor: pops expected events as the design produces them
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int code;
            code = seq_start ? EV_START : seq_abort ? EV_ABORT : blk_done ? EV_DONE : 0;
            if (code != 0) begin
                checks++;
                if (expq.size() == 0) begin
                    fails++;
                    $display("FAIL R4/R8/R12 event: actual %0d expected none", code);
                end else begin
                    int e;
                    e = expq.pop_front();
                    if (e != code) begin
                        fails++;
                        $display("FAIL R4/R8/R12 event: actual %0d expected %0d", code, e);
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1", "pending", pending, 1'b0);
        chk("R1", "in_process", in_process, 1'b0);
        chk("R1", "fe_busy", fe_busy, 1'b0);
        chk("R1", "overflow", overflow, 1'b0);

        // R2 R4 R6: single trigger, held high
        trig_start = 1'b1;
        expect_ev(EV_START);
        tick();
        chk("R6", "pending one waiting", pending, 1'b1);
        chk("R2", "no grant yet", in_process, 1'b0);
        tick();
        chk("R4", "seq_start", seq_start, 1'b1);
        chk("R4", "in_process", in_process, 1'b1);
        chk("R4", "pending after grant", pending, 1'b0);
        tick();
        chk("R4", "seq_start one cycle", seq_start, 1'b0);
        chk("R2", "held level no new request", pending, 1'b0);
        trig_start = 1'b0;

        // R3 R5: host start during run
        host_start = 1'b1;
        tick();
        chk("R3", "run undisturbed", in_process, 1'b1);
        chk("R5", "busy run+wait", fe_busy, 1'b1);
        host_start = 1'b0;
        trig_start = 1'b1;
        tick();
        chk("R6", "pending two", pending, 1'b1);
        chk("R13", "no overflow at two", overflow, 1'b0);
        trig_start = 1'b0;
        tick();
        host_start = 1'b1;
        tick();
        chk("R13", "overflow set", overflow, 1'b1);
        host_start = 1'b0;
        tick();

        // R12 completion then next grant
        expect_ev(EV_DONE);
        expect_ev(EV_START);
        seq_done = 1'b1;
        tick();
        chk("R12", "in_process after done", in_process, 1'b0);
        seq_done = 1'b0;
        tick();
        chk("R4", "regrant", in_process, 1'b1);
        chk("R5", "busy run+one wait", fe_busy, 1'b1);
        tick();

        // R9 clear with one waiting and one in process
        clr_recent = 1'b1;
        tick();
        chk("R9", "run continues", in_process, 1'b1);
        chk("R9", "waiting removed", pending, 1'b0);
        chk("R5", "busy drops", fe_busy, 1'b0);
        clr_recent = 1'b0;
        tick();

        // R8 clear with none waiting, one in process
        expect_ev(EV_ABORT);
        clr_recent = 1'b1;
        tick();
        chk("R8", "aborted", in_process, 1'b0);
        clr_recent = 1'b0;
        tick();
        chk("R13", "overflow sticky", overflow, 1'b1);

        // R7 clear with nothing
        clr_recent = 1'b1;
        tick();
        chk("R7", "empty clear pending", pending, 1'b0);
        chk("R7", "empty clear idle", in_process, 1'b0);
        clr_recent = 1'b0;
        tick();

        // R7 clear with one waiting, idle
        trig_start = 1'b1;
        tick();
        trig_start = 1'b0;
        clr_recent = 1'b1;
        tick();
        chk("R7", "one waiting cleared", pending, 1'b0);
        chk("R7", "no grant after clear", in_process, 1'b0);
        clr_recent = 1'b0;
        tick();
        chk("R7", "still idle", in_process, 1'b0);

        // R7 clear with two waiting, idle
        trig_start = 1'b1;
        host_start = 1'b1;
        tick();
        chk("R5", "busy two waiting", fe_busy, 1'b1);
        trig_start = 1'b0;
        host_start = 1'b0;
        clr_recent = 1'b1;
        expect_ev(EV_START);
        tick();
        chk("R7", "one of two cleared", pending, 1'b0);
        chk("R7", "other granted", in_process, 1'b1);
        clr_recent = 1'b0;
        tick();
        expect_ev(EV_DONE);
        seq_done = 1'b1;
        tick();
        seq_done = 1'b0;
        tick();

        // R10 builder disabled
        builder_en = 1'b0;
        trig_start = 1'b1;
        tick();
        chk("R10", "trigger ignored", pending, 1'b0);
        trig_start = 1'b0;
        tick();
        chk("R10", "no grant", in_process, 1'b0);
        host_start = 1'b1;
        expect_ev(EV_START);
        tick();
        chk("R3", "host accepted when disabled", pending, 1'b1);
        host_start = 1'b0;
        tick();
        tick();
        seq_done = 1'b1;
        tick();
        chk("R10", "no completion pulse", blk_done, 1'b0);
        chk("R12", "finished", in_process, 1'b0);
        seq_done = 1'b0;
        builder_en = 1'b1;
        tick();

        // R11 forced busy
        force_busy = 1'b1;
        tick();
        chk("R11", "forced busy", fe_busy, 1'b1);
        force_busy = 1'b0;
        tick();
        chk("R11", "release busy", fe_busy, 1'b0);

        // R1 initialise
        trig_start = 1'b1;
        host_start = 1'b1;
        tick();
        trig_start = 1'b0;
        host_start = 1'b0;
        expect_ev(EV_START);
        tick();
        tick();
        init = 1'b1;
        tick();
        chk("R1", "init in_process", in_process, 1'b0);
        chk("R1", "init pending", pending, 1'b0);
        chk("R1", "init overflow", overflow, 1'b0);
        chk("R1", "init busy", fe_busy, 1'b0);
        init = 1'b0;
        tick();
        tick();
        chk("R1", "no grant after init", in_process, 1'b0);

        repeat (3) tick();
        checks++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL R12 scoreboard: actual %0d left expected 0", expq.size());
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule